// File: doc/BRIEF.md
# Interval Timer Register Front End

This block is the byte-wide register interface that sits in front of three interval-timer counter channels. Software sees four addresses. Addresses 0 to 2 are the data ports of channels 0 to 2, and address 3 is the control port. The block decodes control words. A control word either programs a channel's access pattern, counting mode and BCD flag, latches a channel's count, or issues a read-back command that can snapshot count and status on several channels at once.

The counters themselves live outside this block. Each 16-bit count is written one byte at a time, so the block assembles the bytes and hands the finished count to the channel with a one-cycle load strobe. It also presents the mode and BCD settings to each channel. The channels return their live count and their OUT level. A load-acknowledge input tells the block when a written count has reached the counter.

Reads are split into bytes according to each channel's access pattern. Every channel has its own write sequence and its own read sequence. Each channel also has a count latch and a status latch, and a read serves them in a fixed priority order. Read data appears on `rdata_o` in the cycle after the read strobe.

Top module: `tmr_ctl_frontend`

## Requirements
- R1: A write to address 3 whose bits 7:6 name channel 0, 1 or 2 and whose bits 5:4 are non-zero stores the access pattern (bits 5:4: 1 = low byte only, 2 = high byte only, 3 = low then high). It also stores the mode (bits 3:1), which drives `mode_o[3c+2:3c]`, and the BCD flag (bit 0), which drives `bcd_o[c]`.
- R2: In low-only access, a data write loads `{8'h00, byte}`. In high-only access, a data write loads `{byte, 8'h00}`. The load appears as a one-cycle `ld_o[c]` pulse with `ld_val_o[16c+15:16c]`, in the cycle after the write.
- R3: In word access, the first data byte is held and nothing is loaded. The second byte loads `{second, first}`, and the sequence then returns to the low byte.
- R4: A control word with bits 5:4 = 0 captures the live count of the named channel. While that captured value is still unread, another capture request for that channel leaves it unchanged.
- R5: A captured count is returned according to the access pattern that was active when it was captured. Word access returns the low byte and then the high byte. Single-byte access returns the one byte. After the last byte, reads see the live count again.
- R6: Bits 7:6 = 3 form a read-back command. Bit c+1 selects channel c. Bit 5 = 0 requests a count capture and bit 4 = 0 requests a status capture. A request for a latch that still holds an unread value is ignored.
- R7: The status byte is {OUT (bit 7), null-count (bit 6), access (bits 5:4), mode (bits 3:1), BCD (bit 0)}. It is sampled at the read-back command.
- R8: A read returns a held status byte first, then a held count, and only then the live count.
- R9: The null-count flag is set by every count load and cleared by `ld_ack_i[c]`.
- R10: Live reads follow the access pattern. Word access alternates between the low byte and the high byte, starting with the low byte.
- R11: A programming control word for a channel restarts both the read sequence and the write sequence of that channel at the low byte.
- R12: After reset, every channel has low-only access, mode 0, BCD 0, null-count 0 and no held latch; `rdata_o` is 0 and no load is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Byte write strobe |
| rd_i | input | 1 | Byte read strobe |
| addr_i | input | 2 | 0..2 channel data port, 3 control port |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after `rd_i` |
| ld_o | output | 3 | Per-channel count load strobe |
| ld_val_o | output | 48 | Per-channel count to load, 16 bits each |
| mode_o | output | 9 | Per-channel mode, 3 bits each |
| bcd_o | output | 3 | Per-channel BCD flag |
| cnt_i | input | 48 | Per-channel live count, 16 bits each |
| out_i | input | 3 | Per-channel OUT level |
| ld_ack_i | input | 3 | Per-channel count-transferred pulse |

## Verification
A wrong write-sequence bit in one channel shifts the bytes of every later count on that channel, and this shows up on `ld_val_o` at the very next load. A wrong read-sequence bit or a latch flag that is never released shows up on the first read that follows: the byte comes from the wrong half, or it is a stale value when a live one was due. For that reason, the stimulus changes the live counts between capture and read. It interleaves captures, read-backs and reads across the channels, so that a latch leaking into a neighbouring channel is exposed within one read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BW = 8;
  localparam int CW = 2 * BW;
  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } acc_e;
endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode #(
  parameter int NCH = 3,
  parameter int AW  = 2
) (
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [NCH-1:0] ctl_we_o,
  output logic [NCH-1:0] lat_cnt_o,
  output logic [NCH-1:0] lat_stat_o,
  output logic [NCH-1:0] data_we_o,
  output logic [NCH-1:0] data_re_o
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NCH);

  logic ctl_wr;
  assign ctl_wr = wr_i && (addr_i == CTRL_ADDR);

  always_comb begin
    ctl_we_o   = '0;
    lat_cnt_o  = '0;
    lat_stat_o = '0;
    data_we_o  = '0;
    data_re_o  = '0;
    for (int c = 0; c < NCH; c++) begin
      data_we_o[c] = wr_i && (addr_i == AW'(c));
      data_re_o[c] = rd_i && (addr_i == AW'(c));
      if (ctl_wr) begin
        if (wdata_i[7:6] == 2'd3) begin
          // read-back: bit c+1 selects, low bits 5/4 request latches
          if (wdata_i[c+1]) begin
            lat_cnt_o[c]  = !wdata_i[5];
            lat_stat_o[c] = !wdata_i[4];
          end
        end else if (wdata_i[7:6] == 2'(c)) begin
          if (wdata_i[5:4] == 2'd0) lat_cnt_o[c] = 1'b1;
          else                      ctl_we_o[c]  = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_we_i,
  input  logic          lat_cnt_i,
  input  logic          lat_stat_i,
  input  logic          data_we_i,
  input  logic          data_re_i,
  input  logic [BW-1:0] wdata_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          out_i,
  input  logic          ld_ack_i,
  output logic [BW-1:0] rd_byte_o,
  output logic          ld_o,
  output logic [CW-1:0] ld_val_o,
  output logic [2:0]    mode_o,
  output logic          bcd_o
);
  acc_e          acc_q, cst_q;
  logic [2:0]    mode_q;
  logic          bcd_q, wr_hi_q, rd_hi_q, stat_v_q, null_q, ld_q;
  logic [BW-1:0] wlat_q, stat_q;
  logic [CW-1:0] clat_q, ldv_q;

  always_comb begin
    if (stat_v_q)                              rd_byte_o = stat_q;
    else if (cst_q == ACC_HI)                  rd_byte_o = clat_q[CW-1:BW];
    else if (cst_q != ACC_LATCH)               rd_byte_o = clat_q[BW-1:0];
    else if (acc_q == ACC_HI)                  rd_byte_o = cnt_i[CW-1:BW];
    else if (acc_q == ACC_WORD && rd_hi_q)     rd_byte_o = cnt_i[CW-1:BW];
    else                                       rd_byte_o = cnt_i[BW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= ACC_LO;
      cst_q    <= ACC_LATCH;
      mode_q   <= '0;
      bcd_q    <= 1'b0;
      wr_hi_q  <= 1'b0;
      rd_hi_q  <= 1'b0;
      stat_v_q <= 1'b0;
      null_q   <= 1'b0;
      ld_q     <= 1'b0;
      wlat_q   <= '0;
      stat_q   <= '0;
      clat_q   <= '0;
      ldv_q    <= '0;
    end else begin
      ld_q <= 1'b0;
      if (ld_ack_i) null_q <= 1'b0;
      if (ctl_we_i) begin
        acc_q   <= acc_e'(wdata_i[5:4]);
        mode_q  <= wdata_i[3:1];
        bcd_q   <= wdata_i[0];
        wr_hi_q <= 1'b0;
        rd_hi_q <= 1'b0;
      end else begin
        if (data_we_i) begin
          unique case (acc_q)
            ACC_LO: begin
              ld_q <= 1'b1; null_q <= 1'b1; ldv_q <= {{BW{1'b0}}, wdata_i};
            end
            ACC_HI: begin
              ld_q <= 1'b1; null_q <= 1'b1; ldv_q <= {wdata_i, {BW{1'b0}}};
            end
            ACC_WORD: begin
              if (!wr_hi_q) begin
                wlat_q  <= wdata_i;
                wr_hi_q <= 1'b1;
              end else begin
                ld_q <= 1'b1; null_q <= 1'b1; ldv_q <= {wdata_i, wlat_q};
                wr_hi_q <= 1'b0;
              end
            end
            default: ;
          endcase
        end
        if (data_re_i) begin
          if (stat_v_q)                stat_v_q <= 1'b0;
          else if (cst_q == ACC_WORD)  cst_q <= ACC_HI;
          else if (cst_q != ACC_LATCH) cst_q <= ACC_LATCH;
          else if (acc_q == ACC_WORD)  rd_hi_q <= !rd_hi_q;
        end
      end
      if (lat_cnt_i && cst_q == ACC_LATCH) begin
        clat_q <= cnt_i;
        cst_q  <= acc_q;
      end
      if (lat_stat_i && !stat_v_q) begin
        stat_q   <= {out_i, null_q, acc_q, mode_q, bcd_q};
        stat_v_q <= 1'b1;
      end
    end
  end

  assign ld_o     = ld_q;
  assign ld_val_o = ldv_q;
  assign mode_o   = mode_q;
  assign bcd_o    = bcd_q;

  // R3: first byte of a word write never loads
  a_r3_word_first_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && !ctl_we_i && acc_q == ACC_WORD && !wr_hi_q) |=> !ld_o);
  // R4: held count survives a second capture request
  a_r4_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_cnt_i && cst_q != ACC_LATCH && !data_re_i) |=> $stable(clat_q));
  // R9: a load always leaves null-count set
  a_r9_null_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_o |-> null_q);
  // R11: programming word restarts both byte sequences
  a_r11_seq_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> (!wr_hi_q && !rd_hi_q));
  // R6: held status ignores a new status request
  a_r6_stat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_stat_i && stat_v_q && !data_re_i) |=> $stable(stat_q));
endmodule

// File: rtl/tmr_ctl_frontend.sv
module tmr_ctl_frontend
  import tmr_pkg::*;
#(
  parameter int NCH = 3,
  localparam int AW = $clog2(NCH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [BW-1:0]     wdata_i,
  output logic [BW-1:0]     rdata_o,
  output logic [NCH-1:0]    ld_o,
  output logic [NCH*CW-1:0] ld_val_o,
  output logic [NCH*3-1:0]  mode_o,
  output logic [NCH-1:0]    bcd_o,
  input  logic [NCH*CW-1:0] cnt_i,
  input  logic [NCH-1:0]    out_i,
  input  logic [NCH-1:0]    ld_ack_i
);
  logic [NCH-1:0] ctl_we, lat_cnt, lat_stat, data_we, data_re;
  logic [BW-1:0]  rd_byte [NCH];
  logic [BW-1:0]  rd_sel;
  logic [BW-1:0]  rdata_q;

  tmr_ctl_decode #(.NCH(NCH), .AW(AW)) i_decode (
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .ctl_we_o   (ctl_we),
    .lat_cnt_o  (lat_cnt),
    .lat_stat_o (lat_stat),
    .data_we_o  (data_we),
    .data_re_o  (data_re)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    tmr_chan_regs i_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ctl_we_i   (ctl_we[c]),
      .lat_cnt_i  (lat_cnt[c]),
      .lat_stat_i (lat_stat[c]),
      .data_we_i  (data_we[c]),
      .data_re_i  (data_re[c]),
      .wdata_i    (wdata_i),
      .cnt_i      (cnt_i[c*CW +: CW]),
      .out_i      (out_i[c]),
      .ld_ack_i   (ld_ack_i[c]),
      .rd_byte_o  (rd_byte[c]),
      .ld_o       (ld_o[c]),
      .ld_val_o   (ld_val_o[c*CW +: CW]),
      .mode_o     (mode_o[c*3 +: 3]),
      .bcd_o      (bcd_o[c])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int c = 0; c < NCH; c++)
      if (addr_i == AW'(c)) rd_sel = rd_byte[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_sel;
  end
  assign rdata_o = rdata_q;

  // R2: only a data write can start a load, at most one channel per cycle
  a_r2_ld_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_o != '0) |-> ($past(wr_i) && $onehot0(ld_o)));
endmodule

// File: tb/test_tmr_ctl_frontend.sv
module test_tmr_ctl_frontend;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [2:0]  ld, bcd, out = '0, ack = '0;
  logic [47:0] ld_val, cnt = '0;
  logic [8:0]  mode;
  int checks = 0, fails = 0, cycles = 0;
  bit  done = 1'b0;
  logic        last_ld;
  logic [15:0] last_val;
  logic [7:0]  rb;

  always #4 clk = ~clk;

  tmr_ctl_frontend i_tmr_ctl_frontend (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ld_o(ld), .ld_val_o(ld_val),
    .mode_o(mode), .bcd_o(bcd), .cnt_i(cnt), .out_i(out), .ld_ack_i(ack));

  function automatic logic [7:0] exp_stat(logic o, logic n, logic [1:0] a,
                                          logic [2:0] m, logic b);
    return {o, n, a, m, b};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_b(logic [1:0] a, logic [7:0] d, int ch = 0);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
    last_ld  = ld[ch];
    last_val = ld_val[ch*16 +: 16];
  endtask

  task automatic rd_b(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 rdata", rdata, 0);
    chk("R12 ld", ld, 0);
    chk("R12 mode", mode, 0);
    chk("R12 bcd", bcd, 0);
    wr_b(3, 8'hE4);               // status read-back ch1
    rd_b(1, rb);
    chk("R12 R7 reset status", rb, exp_stat(0, 0, 2'd1, 3'd0, 0));

    // R1 program ch2: word, mode 5, bcd
    wr_b(3, 8'b10_11_101_1);
    chk("R1 mode ch2", mode[8:6], 5);
    chk("R1 bcd ch2", bcd[2], 1);

    // R2 low only / high only on ch0
    wr_b(3, 8'h10);
    wr_b(0, 8'hA5, 0);
    chk("R2 lo ld", last_ld, 1);
    chk("R2 lo val", last_val, 16'h00A5);
    wr_b(3, 8'h20);
    wr_b(0, 8'h3C, 0);
    chk("R2 hi val", last_val, 16'h3C00);

    // R3 word write ch1
    wr_b(3, 8'h74);
    wr_b(1, 8'h34, 1);
    chk("R3 first byte no load", last_ld, 0);
    wr_b(1, 8'h12, 1);
    chk("R3 word ld", last_ld, 1);
    chk("R3 word val", last_val, 16'h1234);

    // R9 null-count set then cleared
    out[1] = 1'b1;
    wr_b(3, 8'hE4);
    rd_b(1, rb);
    chk("R9 R7 null set", rb, exp_stat(1, 1, 2'd3, 3'd2, 0));
    @(negedge clk); ack[1] = 1'b1;
    @(negedge clk); ack[1] = 1'b0;
    wr_b(3, 8'hE4);
    rd_b(1, rb);
    chk("R9 null cleared", rb, exp_stat(1, 0, 2'd3, 3'd2, 0));

    // R8 priority status > count > live, R5 word latch
    cnt[31:16] = 16'hBEEF;
    wr_b(3, 8'hC4);
    cnt[31:16] = 16'h0000;
    rd_b(1, rb); chk("R8 status first", rb, exp_stat(1, 0, 2'd3, 3'd2, 0));
    rd_b(1, rb); chk("R8 R5 count lo", rb, 8'hEF);
    rd_b(1, rb); chk("R5 count hi", rb, 8'hBE);
    cnt[31:16] = 16'h5678;
    rd_b(1, rb); chk("R10 live lo", rb, 8'h78);
    rd_b(1, rb); chk("R10 live hi", rb, 8'h56);

    // R4 second capture ignored
    cnt[31:16] = 16'h1111;
    wr_b(3, 8'h40);
    cnt[31:16] = 16'h2222;
    wr_b(3, 8'h40);
    rd_b(1, rb); chk("R4 held lo", rb, 8'h11);
    rd_b(1, rb); chk("R4 held hi", rb, 8'h11);
    rd_b(1, rb); chk("R5 released live lo", rb, 8'h22);
    rd_b(1, rb);

    // R6 status request ignored while held
    wr_b(3, 8'hE4);
    out[1] = 1'b0;
    wr_b(3, 8'hE4);
    rd_b(1, rb); chk("R6 held status", rb[7], 1);
    cnt[31:16] = 16'h9A3B;
    rd_b(1, rb); chk("R6 status released", rb, 8'h3B);
    rd_b(1, rb);

    // R5 single-byte latch on ch0 (high only)
    cnt[15:0] = 16'hABCD;
    wr_b(3, 8'h00);
    cnt[15:0] = 16'h4321;
    rd_b(0, rb); chk("R5 hi-only latch", rb, 8'hAB);
    rd_b(0, rb); chk("R5 hi-only live", rb, 8'h43);

    // R11 restart sequences
    cnt[31:16] = 16'hC0DE;
    wr_b(1, 8'h99, 1);
    rd_b(1, rb);
    wr_b(3, 8'h74);
    wr_b(1, 8'h01, 1);
    chk("R11 write restarted", last_ld, 0);
    wr_b(1, 8'h02, 1);
    chk("R11 word val", last_val, 16'h0201);
    rd_b(1, rb); chk("R11 read restarted", rb, 8'hDE);
    rd_b(1, rb);

    // R6 multi-channel count read-back
    cnt = {16'h3333, 16'h2222, 16'h1111};
    wr_b(3, 8'hDE);
    cnt = '0;
    rd_b(0, rb); chk("R6 ch0", rb, 8'h11);
    rd_b(1, rb); chk("R6 ch1 lo", rb, 8'h22);
    rd_b(2, rb); chk("R6 ch2 lo", rb, 8'h33);
    rd_b(1, rb); chk("R6 ch1 hi", rb, 8'h22);
    rd_b(2, rb); chk("R6 ch2 hi", rb, 8'h33);
    rd_b(0, rb); chk("R6 ch0 released", rb, 8'h00);

    // random: R1 R2 R3 R10
    for (int i = 0; i < 200; i++) begin
      int ch = $urandom_range(0, 2);
      logic [1:0]  acc = 2'($urandom_range(1, 3));
      logic [2:0]  md = 3'($urandom);
      logic [7:0]  b0 = 8'($urandom), b1 = 8'($urandom);
      logic [15:0] lv = 16'($urandom);
      wr_b(3, {2'(ch), acc, md, 1'b0});
      chk("R1 rand mode", mode[ch*3 +: 3], md);
      if (acc == 2'd3) begin
        wr_b(2'(ch), b0, ch);
        chk("R3 rand held", last_ld, 0);
        wr_b(2'(ch), b1, ch);
        chk("R3 rand val", last_val, {b1, b0});
      end else begin
        wr_b(2'(ch), b0, ch);
        chk("R2 rand val", last_val, acc == 2'd1 ? {8'h00, b0} : {b0, 8'h00});
      end
      cnt[ch*16 +: 16] = lv;
      rd_b(2'(ch), rb);
      chk("R10 rand first", rb, acc == 2'd2 ? lv[15:8] : lv[7:0]);
      if (acc == 2'd3) begin
        rd_b(2'(ch), rb);
        chk("R10 rand second", rb, lv[15:8]);
      end
    end
    finish_run();
  end
endmodule